// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Carry, Overflow and Condition Flags

This block is the fixed-point add/subtract slice of a 32-bit integer pipeline. It forms a result from two operands in one combinational pass. It also holds the architectural flag state that arithmetic instructions update: a carry bit, an overflow bit and a sticky summary-overflow bit, plus a four-bit condition field. The condition field records whether the result is negative, positive or zero, and it carries a copy of the summary overflow.

Each operation is picked by a three-bit code. Three per-instruction enables say which flag groups the instruction records. The block shows, in the same cycle, the result and the flag values the instruction would leave behind. The flag registers take those values at the clock edge when the valid strobe is high. The extended forms read the stored carry as their carry-in, so chains of extended operations build wide arithmetic across several instructions.

Top module: `addsub_flags_unit`

## Requirements
- R1: With valid high, the code on opSel selects the result: 0 gives opA+opB, 5 gives opA plus opB[15:0] shifted up by 16 bits, and 7 behaves like code 0.
- R2: Code 1 (subtract-from) yields opB minus opA, never opA minus opB.
- R3: The extended codes take the stored carry bit as carry-in: 2 gives opA+opB+CA, 3 gives opA+0+CA, 4 gives opA+0xFFFFFFFF+CA, and 6 gives ~opA+opB+CA.
- R4: When recCarry is high, or the code is extended (2, 3, 4 or 6), nextCa is the carry out of bit 31. For subtraction this means it is 1 exactly when no borrow occurred.
- R5: When recOvf is high, nextOv is the signed overflow of the operation and nextSo is soQ ORed with that overflow. Only reset ever clears soQ.
- R6: When recCond is high, nextCr is {LT, GT, EQ, SO} from bit 3 down to bit 0. LT is the result sign bit, GT is set when the result is nonzero with a clear sign bit, EQ is set when the result is zero, and SO equals nextSo.
- R7: A flag group whose enable is low shows its current register value on its next output: CA when recCarry is low on a non-extended code, OV and SO when recOvf is low, and the condition field when recCond is low.
- R8: caQ, ovQ, soQ and crQ take nextCa, nextOv, nextSo and nextCr at a rising clock edge with valid high, and hold their values when valid is low.
- R9: A synchronous reset high at a rising edge clears caQ, ovQ, soQ and crQ to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Instruction strobe; flag registers load when high |
| opSel | input | 3 | Operation code |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand (its low 16 bits form the immediate for code 5) |
| recCarry | input | 1 | Record carry |
| recOvf | input | 1 | Record overflow and summary overflow |
| recCond | input | 1 | Record condition field |
| result | output | 32 | Arithmetic result |
| nextCa | output | 1 | Carry bit after this operation |
| nextOv | output | 1 | Overflow bit after this operation |
| nextSo | output | 1 | Summary overflow after this operation |
| nextCr | output | 4 | Condition field after this operation {LT,GT,EQ,SO} |
| caQ | output | 1 | Stored carry |
| ovQ | output | 1 | Stored overflow |
| soQ | output | 1 | Stored summary overflow |
| crQ | output | 4 | Stored condition field |

## Verification
A bad stored carry shows up in the very next extended operation. Its result and nextCa are then off by one in the same cycle, so the vector table chains extended codes straight after operations that set or clear the carry. If the summary-overflow bit is cleared or left unset, the SO bit of every later recorded condition field is wrong. The bench therefore keeps checking nextCr and crQ long after the overflow that set it, and it confirms that only reset clears the bit. Registers that load without the valid strobe, or that ignore a disabled enable, differ from the bench model one edge after the stimulus.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUBF  = 3'd1,
    OP_ADDE  = 3'd2,
    OP_ADDZE = 3'd3,
    OP_ADDME = 3'd4,
    OP_ADDIS = 3'd5,
    OP_SUBFE = 3'd6,
    OP_SPARE = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    SRC_B,
    SRC_IMMHI,
    SRC_ZERO,
    SRC_ONES
  } bsrc_e;

  typedef enum logic [1:0] {
    CIN_ZERO,
    CIN_ONE,
    CIN_CARRY
  } cin_e;

  typedef struct packed {
    logic  invA;
    bsrc_e bSrc;
    cin_e  cinSel;
    logic  wrCa;
    logic  wrOv;
    logic  wrCr;
    logic  load;
  } strobes_t;

endpackage

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_pkg::*;
(
  input  logic     valid,
  input  logic [2:0] opSel,
  input  logic     recCarry,
  input  logic     recOvf,
  input  logic     recCond,
  output strobes_t ctl
);

  logic isExt;

  always_comb begin
    ctl.invA   = 1'b0;
    ctl.bSrc   = SRC_B;
    ctl.cinSel = CIN_ZERO;
    isExt      = 1'b0;
    case (opcode_e'(opSel))
      OP_SUBF:  begin ctl.invA = 1'b1; ctl.cinSel = CIN_ONE; end
      OP_ADDE:  begin ctl.cinSel = CIN_CARRY; isExt = 1'b1; end
      OP_ADDZE: begin ctl.bSrc = SRC_ZERO; ctl.cinSel = CIN_CARRY; isExt = 1'b1; end
      OP_ADDME: begin ctl.bSrc = SRC_ONES; ctl.cinSel = CIN_CARRY; isExt = 1'b1; end
      OP_ADDIS: ctl.bSrc = SRC_IMMHI;
      OP_SUBFE: begin ctl.invA = 1'b1; ctl.cinSel = CIN_CARRY; isExt = 1'b1; end
      default:  ;
    endcase
    ctl.wrCa = recCarry | isExt;
    ctl.wrOv = recOvf;
    ctl.wrCr = recCond;
    ctl.load = valid;
  end

  // R4
  always_comb begin
    extCarryChk : assert (!isExt || ctl.cinSel == CIN_CARRY);
  end

endmodule

// File: rtl/addsub_datapath.sv
module addsub_datapath
  import addsub_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  strobes_t         ctl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             nextCa,
  output logic             nextOv,
  output logic             nextSo,
  output logic [3:0]       nextCr,
  output logic             caQ,
  output logic             ovQ,
  output logic             soQ,
  output logic [3:0]       crQ
);

  localparam int MSB = WIDTH - 1;
  localparam int PAD = WIDTH - IMM_W;

  logic [WIDTH-1:0] xOp, yOp;
  logic             cin;
  logic [WIDTH:0]   sumExt;
  logic             carryOut, ovf;
  logic             isNeg, isZero;

  always_comb begin
    xOp = ctl.invA ? ~opA : opA;
    case (ctl.bSrc)
      SRC_IMMHI: yOp = {opB[IMM_W-1:0], {PAD{1'b0}}};
      SRC_ZERO:  yOp = '0;
      SRC_ONES:  yOp = '1;
      default:   yOp = opB;
    endcase
    case (ctl.cinSel)
      CIN_ONE:   cin = 1'b1;
      CIN_CARRY: cin = caQ;
      default:   cin = 1'b0;
    endcase
    sumExt = {1'b0, xOp} + {1'b0, yOp} + {{WIDTH{1'b0}}, cin};
  end

  assign result   = sumExt[MSB:0];
  assign carryOut = sumExt[WIDTH];
  assign ovf      = (xOp[MSB] == yOp[MSB]) && (result[MSB] != xOp[MSB]);
  assign isNeg    = result[MSB];
  assign isZero   = (result == '0);

  assign nextCa = ctl.wrCa ? carryOut : caQ;
  assign nextOv = ctl.wrOv ? ovf : ovQ;
  assign nextSo = soQ | (ctl.wrOv & ovf);
  assign nextCr = ctl.wrCr ? {isNeg, !isZero && !isNeg, isZero, nextSo} : crQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      caQ <= 1'b0;
      ovQ <= 1'b0;
      soQ <= 1'b0;
      crQ <= 4'b0;
    end else if (ctl.load) begin
      caQ <= nextCa;
      ovQ <= nextOv;
      soQ <= nextSo;
      crQ <= nextCr;
    end
  end

  // R5
  so_sticky_chk : assert property (@(posedge clk) disable iff (rst)
    soQ |=> soQ);

  // R8
  hold_idle_chk : assert property (@(posedge clk) disable iff (rst)
    !ctl.load |=> $stable({caQ, ovQ, soQ, crQ}));

  // R6
  cr_sign_chk : assert property (@(posedge clk) disable iff (rst)
    $onehot0(crQ[3:1]));

  // R6
  cr_so_chk : assert property (@(posedge clk) disable iff (rst)
    (ctl.load && ctl.wrCr) |=> (crQ[0] == soQ));

  // R7
  ov_keep_chk : assert property (@(posedge clk) disable iff (rst)
    (ctl.load && !ctl.wrOv) |=> $stable({ovQ, soQ}));

  // R9
  reset_clear_chk : assert property (@(posedge clk)
    rst |=> ({caQ, ovQ, soQ, crQ} == 7'b0));

endmodule

// File: rtl/addsub_flags_unit.sv
module addsub_flags_unit
  import addsub_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [2:0]       opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             recCarry,
  input  logic             recOvf,
  input  logic             recCond,
  output logic [WIDTH-1:0] result,
  output logic             nextCa,
  output logic             nextOv,
  output logic             nextSo,
  output logic [3:0]       nextCr,
  output logic             caQ,
  output logic             ovQ,
  output logic             soQ,
  output logic [3:0]       crQ
);

  strobes_t ctl;

  addsub_ctrl u_ctrl (
    .valid    (valid),
    .opSel    (opSel),
    .recCarry (recCarry),
    .recOvf   (recOvf),
    .recCond  (recCond),
    .ctl      (ctl)
  );

  addsub_datapath #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .opA    (opA),
    .opB    (opB),
    .result (result),
    .nextCa (nextCa),
    .nextOv (nextOv),
    .nextSo (nextSo),
    .nextCr (nextCr),
    .caQ    (caQ),
    .ovQ    (ovQ),
    .soQ    (soQ),
    .crQ    (crQ)
  );

endmodule

// File: tb/addsub_flags_unit_test.sv
`timescale 1ns/1ps
module addsub_flags_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic [31:0] opA = '0, opB = '0;
  logic        recCarry = 1'b0, recOvf = 1'b0, recCond = 1'b0;
  logic [31:0] result;
  logic        nextCa, nextOv, nextSo, caQ, ovQ, soQ;
  logic [3:0]  nextCr, crQ;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  addsub_flags_unit uut (
    .clk(clk), .rst(rst), .valid(valid), .opSel(opSel), .opA(opA), .opB(opB),
    .recCarry(recCarry), .recOvf(recOvf), .recCond(recCond),
    .result(result), .nextCa(nextCa), .nextOv(nextOv), .nextSo(nextSo),
    .nextCr(nextCr), .caQ(caQ), .ovQ(ovQ), .soQ(soQ), .crQ(crQ)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [2:0]  rec;   // {recCarry, recOvf, recCond}
    logic [31:0] expR;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 32'd5,          32'd7,          3'b111, 32'h0000000C},
    '{3'd0, 32'h7FFFFFFF,   32'd1,          3'b111, 32'h80000000},
    '{3'd1, 32'd3,          32'd10,         3'b111, 32'd7},
    '{3'd1, 32'd10,         32'd3,          3'b111, 32'hFFFFFFF9},
    '{3'd2, 32'd1,          32'd2,          3'b111, 32'd3},
    '{3'd0, 32'hFFFFFFFF,   32'd1,          3'b111, 32'd0},
    '{3'd3, 32'd5,          32'hDEADBEEF,   3'b001, 32'd6},
    '{3'd4, 32'd0,          32'h12345678,   3'b011, 32'hFFFFFFFF},
    '{3'd4, 32'd5,          32'd0,          3'b001, 32'd4},
    '{3'd2, 32'h10,         32'h20,         3'b111, 32'h31},
    '{3'd5, 32'h1234,       32'hABCD0001,   3'b001, 32'h00011234},
    '{3'd6, 32'd5,          32'd9,          3'b111, 32'd3},
    '{3'd6, 32'd5,          32'd9,          3'b111, 32'd4}
  };

  // bench model of the flag state
  logic        mCa = 0, mOv = 0, mSo = 0;
  logic [3:0]  mCr = 0;
  logic [31:0] eR;
  logic        eCa, eOv, eSo;
  logic [3:0]  eCr;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [2:0] rec);
    logic [32:0] s;
    longint sx;
    logic cy, ovf, rc, ro, rr, ext;
    logic [31:0] x, y;
    logic cin;
    rc = rec[2]; ro = rec[1]; rr = rec[0];
    ext = (op == 3'd2) || (op == 3'd3) || (op == 3'd4) || (op == 3'd6);
    if (op == 3'd1) begin
      s  = {1'b0, b} - {1'b0, a};
      eR = s[31:0];
      cy = (b >= a);
      sx = longint'($signed(b)) - longint'($signed(a));
    end else begin
      x = a; cin = 1'b0;
      case (op)
        3'd2: begin y = b; cin = mCa; end
        3'd3: begin y = 32'd0; cin = mCa; end
        3'd4: begin y = 32'hFFFFFFFF; cin = mCa; end
        3'd5: y = {b[15:0], 16'h0};
        3'd6: begin x = ~a; y = b; cin = mCa; end
        default: y = b;
      endcase
      s  = {1'b0, x} + {1'b0, y} + {32'd0, cin};
      eR = s[31:0];
      cy = s[32];
      sx = longint'($signed(x)) + longint'($signed(y)) + longint'(cin);
    end
    ovf = (sx > 64'sd2147483647) || (sx < -64'sd2147483648);
    eCa = (rc || ext) ? cy : mCa;
    eOv = ro ? ovf : mOv;
    eSo = mSo | (ro & ovf);
    eCr = rr ? {eR[31], (eR != 0) && !eR[31], eR == 0, eSo} : mCr;
  endtask

  task automatic doOp(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic [2:0] rec, input logic v, input bit chkRes,
                      input logic [31:0] expR, input string tag);
    @(negedge clk);
    opSel = op; opA = a; opB = b;
    recCarry = rec[2]; recOvf = rec[1]; recCond = rec[0]; valid = v;
    model(op, a, b, rec);
    #1;
    if (chkRes) check(tag, "table result", result, expR);
    check(tag, "model result", result, eR);
    check("R4", "nextCa", {31'd0, nextCa}, {31'd0, eCa});
    check("R5", "nextOv", {31'd0, nextOv}, {31'd0, eOv});
    check("R5", "nextSo", {31'd0, nextSo}, {31'd0, eSo});
    check("R6", "nextCr", {28'd0, nextCr}, {28'd0, eCr});
    @(posedge clk);
    #1;
    if (v) begin mCa = eCa; mOv = eOv; mSo = eSo; mCr = eCr; end
    check("R8", "stored flags", {25'd0, caQ, ovQ, soQ, crQ}, {25'd0, mCa, mOv, mSo, mCr});
  endtask

  function automatic string tagFor(input logic [2:0] op);
    if (op == 3'd1) return "R2";
    if (op == 3'd2 || op == 3'd3 || op == 3'd4 || op == 3'd6) return "R3";
    return "R1";
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9", "flags after reset", {25'd0, caQ, ovQ, soQ, crQ}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++)
      doOp(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].rec, 1'b1, 1'b1,
           VECS[i].expR, tagFor(VECS[i].op));

    // R8: valid low does not load, though next outputs show the update
    doOp(3'd0, 32'hFFFFFFFF, 32'd1, 3'b111, 1'b0, 1'b1, 32'd0, "R8");
    // R7: condition recording off keeps crQ
    doOp(3'd0, 32'd0, 32'd0, 3'b110, 1'b1, 1'b1, 32'd0, "R7");
    check("R7", "crQ kept", {28'd0, crQ}, {28'd0, mCr});
    // R7: overflow recording off, overflowing add leaves OV/SO
    doOp(3'd0, 32'h7FFFFFFF, 32'd1, 3'b001, 1'b1, 1'b1, 32'h80000000, "R7");
    // R7: carry not recorded on plain add with carry out
    doOp(3'd0, 32'hFFFFFFFF, 32'd2, 3'b011, 1'b1, 1'b1, 32'd1, "R7");
    // R2/R5: subtract-from overflow (0x80000000 - 1)
    doOp(3'd1, 32'd1, 32'h80000000, 3'b111, 1'b1, 1'b1, 32'h7FFFFFFF, "R2");
    check("R5", "ovQ set", {31'd0, ovQ}, 32'd1);
    // R5: no overflow clears OV, SO remains
    doOp(3'd7, 32'd1, 32'd1, 3'b111, 1'b1, 1'b1, 32'd2, "R1");
    check("R5", "so sticky", {30'd0, ovQ, soQ}, 32'd1);

    // R9: reset clears everything
    @(negedge clk);
    rst = 1'b1; valid = 1'b0;
    @(posedge clk);
    #1;
    check("R9", "flags after second reset", {25'd0, caQ, ovQ, soQ, crQ}, 32'd0);
    mCa = 0; mOv = 0; mSo = 0; mCr = 0;
    @(negedge clk);
    rst = 1'b0;
    doOp(3'd0, 32'd0, 32'd0, 3'b111, 1'b1, 1'b1, 32'd0, "R6");
    check("R6", "EQ only after reset", {28'd0, crQ}, 32'h2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule